// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous 16-bit static memory with two active-low byte-lane selects. The host hands over one word access at a time with a valid/ready handshake. The block then plays out the memory's chip-select, write-strobe, output-enable and lane-select sequence, and it controls its own data drivers. Every interval of that sequence is a whole number of clock cycles. Each count is the nanosecond minimum divided by the clock period, rounded up, and is never less than one.

A write happens only while chip select, write strobe and at least one lane select are all low. The write strobe rises first and so ends each write. Before a write, output enable is taken high and held high for a turnaround count, so that the memory has let go of the bus before the data drivers turn on. A read keeps chip select, output enable and the requested lanes low for the read-cycle count. It captures the bus on the last cycle of the access-time count and returns the word with a one-cycle response pulse.

Top module: `asram_seq`

## Requirements
- R1: During and after reset, memCeN, memWeN, memOeN and both memBenN bits are high, memDoutEn is low, reqReady is high and rspValid is low.
- R2: reqReady is high only when the block is idle. After a request is accepted it stays low for RC cycles on a read and for TURN+PULSE+REC cycles on a write.
- R3: A read holds memCeN and memOeN low and memWeN high for RC consecutive cycles. rspValid pulses for exactly one cycle, AA+1 cycles after acceptance. rspData is the memDin word present on the AA-th cycle of the read.
- R4: Whenever memCeN is low, memAddr equals the address of the accepted request and does not change.
- R5: memDoutEn is never high while memOeN is low. On a write, memOeN is high for at least TURN cycles before memDoutEn rises.
- R6: memWeN stays low for PULSE = max(ceil(tPulse), ceil(tSetup)) cycles. memDout is driven and unchanged for at least ceil(tSetup) cycles before memWeN rises.
- R7: memDoutEn stays high for the cycle after memWeN rises. A write keeps memCeN low for at least WC cycles.
- R8: reqBen bit 0 selects the low byte (memBenN[0], data bits 7:0) and bit 1 selects the high byte (memBenN[1], bits 15:8). A selected lane's select bit is low while memCeN is low and an unselected one stays high. A write with reqBen = 0 changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle, request accepted this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqBen | input | 2 | Byte-lane selects, active high |
| rspValid | output | 1 | One-cycle read response strobe |
| rspData | output | 16 | Captured read word |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memBenN | output | 2 | Lane selects, active low |
| memDout | output | 16 | Data toward memory |
| memDoutEn | output | 1 | Data driver enable |
| memDin | input | 16 | Data from memory |

## Verification
The bench runs a read straight after a write and a write straight after a read. A sequencer that skipped the turnaround there would turn its drivers on while output enable was still low, or within fewer than TURN cycles of its release, and the checker flags that as bus contention. It also measures each write-strobe pulse, the run of stable data before the strobe rises, and the hold cycle after it. A pulse that is one cycle short, or data that changes late, shows up as a measured count below its bound. Partial-lane writes to one address, a write with no lanes selected, and read-back through a memory model that floats its unselected lanes at zero expose lanes that are swapped or ignored. The bench also compares the ready and response timing with its own countdown model on every cycle, so a capture taken one cycle off returns a stale word or a misplaced pulse.

// File: rtl/asram_seq_pkg.sv
package asram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_PULSE,
    ST_RECOVER
  } seqState_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic chip;
    logic outEn;
    logic wrStrobe;
    logic lanes;
    logic drive;
  } seqStrobe_t;

  function automatic int ceilCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/asram_seq_ctrl.sv
module asram_seq_ctrl
  import asram_seq_pkg::*;
#(
  parameter int RC_C    = 7,
  parameter int AA_C    = 7,
  parameter int TURN_C  = 3,
  parameter int PULSE_C = 5,
  parameter int REC_C   = 1,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output seqStrobe_t strb
);

  localparam logic [CNT_W-1:0] RcLast    = CNT_W'(RC_C - 1);
  localparam logic [CNT_W-1:0] AaLast    = CNT_W'(AA_C - 1);
  localparam logic [CNT_W-1:0] TurnLast  = CNT_W'(TURN_C - 1);
  localparam logic [CNT_W-1:0] PulseLast = CNT_W'(PULSE_C - 1);
  localparam logic [CNT_W-1:0] RecLast   = CNT_W'(REC_C - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (reqValid) stateNext = reqWrite ? ST_TURN : ST_READ;
      end
      ST_READ:    if (cnt == RcLast)    begin stateNext = ST_IDLE;    cntNext = '0; end
      ST_TURN:    if (cnt == TurnLast)  begin stateNext = ST_PULSE;   cntNext = '0; end
      ST_PULSE:   if (cnt == PulseLast) begin stateNext = ST_RECOVER; cntNext = '0; end
      ST_RECOVER: if (cnt == RecLast)   begin stateNext = ST_IDLE;    cntNext = '0; end
      default: begin stateNext = ST_IDLE; cntNext = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    reqReady      = (state == ST_IDLE);
    strb.load     = (state == ST_IDLE) && reqValid;
    strb.capture  = (state == ST_READ) && (cnt == AaLast);
    strb.chip     = (state != ST_IDLE);
    strb.outEn    = (state == ST_READ);
    strb.wrStrobe = (state == ST_PULSE);
    strb.lanes    = (state != ST_IDLE);
    strb.drive    = (state == ST_PULSE) || (state == ST_RECOVER);
  end

  // R2: an accepted request makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  // R3: the capture strobe only fires inside a read
  p_capture_read_r3: assert property (@(posedge clk) disable iff (rst)
    strb.capture |-> (strb.outEn && !strb.wrStrobe));

endmodule

// File: rtl/asram_seq_dpath.sv
module asram_seq_dpath
  import asram_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBen,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBenN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  benQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      dataQ    <= '0;
      benQ     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        benQ  <= reqBen;
      end
      rspValid <= strb.capture;
      if (strb.capture) rspData <= memDin;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = dataQ;
  assign memCeN    = ~strb.chip;
  assign memWeN    = ~strb.wrStrobe;
  assign memOeN    = ~strb.outEn;
  assign memDoutEn = strb.drive;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memBenN[i] = ~(strb.lanes & benQ[i]);
  end

  // R4: address frozen while the chip is selected
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R5: drivers never fight the memory's output
  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> memOeN);
  p_oe_released_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(memDoutEn) |-> (memOeN && $past(memOeN)));

  // R6: data driven and steady through the write pulse
  p_data_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && $past(!memWeN)) |-> ($stable(memDout) && memDoutEn));

  // R3: single-cycle response strobe
  p_rsp_single_r3: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_TURN_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBen,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBenN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int RcC    = ceilCycles(T_RC_NS, CLK_NS);
  localparam int AaRaw  = ceilCycles(T_AA_NS, CLK_NS);
  localparam int AaC    = (AaRaw > RcC) ? RcC : AaRaw;
  localparam int TurnC  = ceilCycles(T_TURN_NS, CLK_NS);
  localparam int PweC   = ceilCycles(T_PWE_NS, CLK_NS);
  localparam int SdC    = ceilCycles(T_SD_NS, CLK_NS);
  localparam int PulseC = (PweC > SdC) ? PweC : SdC;
  localparam int WcC    = ceilCycles(T_WC_NS, CLK_NS);
  localparam int RecRaw = WcC - TurnC - PulseC;
  localparam int RecC   = (RecRaw > 1) ? RecRaw : 1;
  localparam int Max1   = (RcC > TurnC) ? RcC : TurnC;
  localparam int Max2   = (PulseC > RecC) ? PulseC : RecC;
  localparam int MaxC   = (Max1 > Max2) ? Max1 : Max2;
  localparam int CntW   = $clog2(MaxC + 1);

  seqStrobe_t strb;

  asram_seq_ctrl #(
    .RC_C(RcC), .AA_C(AaC), .TURN_C(TurnC),
    .PULSE_C(PulseC), .REC_C(RecC), .CNT_W(CntW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  asram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBen(reqBen),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memBenN(memBenN), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

endmodule

// File: tb/asram_seq_tb.sv
module asram_seq_tb;

  localparam int CLK = 8;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RC    = cyc(55);
  localparam int AA    = cyc(55);
  localparam int TURN  = cyc(20);
  localparam int SD    = cyc(25);
  localparam int PULSE = (cyc(40) > SD) ? cyc(40) : SD;
  localparam int WC    = cyc(55);
  localparam int REC   = (WC - TURN - PULSE > 1) ? WC - TURN - PULSE : 1;
  localparam int WT    = TURN + PULSE + REC;

  logic        clk = 0, rst = 1;
  logic        reqValid = 0, reqWrite = 0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBen = '0;
  logic        reqReady, rspValid, memCeN, memWeN, memOeN, memDoutEn;
  logic [15:0] rspData, memDout;
  logic [16:0] memAddr;
  logic [1:0]  memBenN;
  logic [15:0] memDin = '0;

  always #4 clk = ~clk;

  asram_seq u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBen(reqBen),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memBenN(memBenN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  int nChecks = 0, nErr = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] laneMask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  // device model and reference memory
  logic [15:0] devMem [int];
  logic [15:0] refMem [int];
  function automatic logic [15:0] devRd(input int a);
    return devMem.exists(a) ? devMem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] refRd(input int a);
    return refMem.exists(a) ? refMem[a] : 16'h0;
  endfunction

  // reference timing model
  int          expBusy = 0, expRspIn = 0;
  logic [15:0] expData = '0;
  logic [16:0] expAddr = '0;
  logic [1:0]  expBen = '0;

  always @(posedge clk) begin
    if (rst) begin
      expBusy = 0; expRspIn = 0;
    end else begin
      bit wasIdle;
      wasIdle = (expBusy == 0);
      if (expRspIn > 0) expRspIn--;
      if (expBusy > 0) expBusy--;
      if (reqValid && wasIdle) begin
        expAddr = reqAddr; expBen = reqBen;
        if (reqWrite) begin
          expBusy = WT;
          refMem[int'(reqAddr)] = (refRd(int'(reqAddr)) & ~laneMask(reqBen)) | (reqWdata & laneMask(reqBen));
        end else begin
          expBusy = RC;
          expRspIn = AA + 1;
          expData = refRd(int'(reqAddr)) & laneMask(reqBen);
        end
      end
    end
  end

  // device behaviour and pin timing checker, all at the falling edge
  int weRun = 0, dataRun = 0, ceRun = 0, oeHigh = 0;
  bit sawWe = 0, prevEn = 0, ovPrev = 0;
  logic [15:0] prevDout = '0, ovData = '0;
  logic [1:0]  ovLanes = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit ov;
      // R2 / R3 cycle compare against the reference
      check(reqReady == (expBusy == 0), "R2 ready", reqReady, expBusy == 0);
      check(rspValid == (expRspIn == 1), "R3 rspValid", rspValid, expRspIn == 1);
      if (expRspIn == 1) check(rspData == expData, "R3 rspData", rspData, expData);
      if (!memCeN) begin
        check(memAddr == expAddr, "R4 addr", memAddr, expAddr);
        check(memBenN == ~expBen, "R8 lanes", memBenN, ~expBen);
      end
      // write pulse end
      if (memWeN && weRun > 0) begin
        check(weRun >= PULSE, "R6 pulse", weRun, PULSE);
        check(dataRun >= SD, "R6 setup", dataRun, SD);
        check(memDoutEn, "R7 hold", memDoutEn, 1);
      end
      weRun = memWeN ? 0 : weRun + 1;
      if (memDoutEn && prevEn && memDout == prevDout) dataRun++;
      else dataRun = memDoutEn ? 1 : 0;
      prevEn = memDoutEn; prevDout = memDout;
      // chip select span
      if (!memCeN) begin
        ceRun++;
        if (!memWeN) sawWe = 1;
      end else begin
        if (ceRun > 0) begin
          if (sawWe) check(ceRun >= WC, "R7 write cycle", ceRun, WC);
          else       check(ceRun >= RC, "R3 read cycle", ceRun, RC);
        end
        ceRun = 0; sawWe = 0;
      end
      // turnaround
      oeHigh = memOeN ? oeHigh + 1 : 0;
      if (memDoutEn) check(memOeN && oeHigh >= TURN + 1, "R5 turnaround", oeHigh, TURN + 1);
      // device write on end of overlap
      ov = !memCeN && !memWeN && (memBenN != 2'b11);
      if (ov) begin ovData = memDout; ovLanes = ~memBenN; end
      if (ovPrev && !ov)
        devMem[int'(memAddr)] = (devRd(int'(memAddr)) & ~laneMask(ovLanes)) | (ovData & laneMask(ovLanes));
      ovPrev = ov;
      // device read drive
      if (!memCeN && !memOeN && memWeN) memDin <= devRd(int'(memAddr)) & laneMask(~memBenN);
      else memDin <= 16'h0;
    end
  end

  task automatic doReq(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] b);
    bit rdy;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBen = b;
    forever begin
      rdy = reqReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memCeN && memWeN && memOeN, "R1 strobes", {memCeN, memWeN, memOeN}, 3'b111);
    check(memBenN == 2'b11, "R1 lanes", memBenN, 2'b11);
    check(!memDoutEn, "R1 driver", memDoutEn, 0);
    check(reqReady && !rspValid, "R1 handshake", {reqReady, rspValid}, 2'b10);
    rst = 0;
    @(negedge clk);
    // full word write and read back (R3, R6)
    doReq(1, 17'h00010, 16'hA5C3, 2'b11);
    doReq(0, 17'h00010, 16'h0, 2'b11);
    // lane merging at top address (R8)
    doReq(1, 17'h1FFFF, 16'h1234, 2'b01);
    doReq(1, 17'h1FFFF, 16'hABCD, 2'b10);
    doReq(0, 17'h1FFFF, 16'h0, 2'b11);
    doReq(0, 17'h1FFFF, 16'h0, 2'b01);
    doReq(0, 17'h1FFFF, 16'h0, 2'b10);
    // no-lane write leaves memory unchanged (R8)
    doReq(1, 17'h00010, 16'hFFFF, 2'b00);
    doReq(0, 17'h00010, 16'h0, 2'b11);
    // mixed traffic with idle gaps and back-to-back turns (R2, R5)
    begin
      logic [31:0] lfsr;
      lfsr = 32'h1ACE5EED;
      for (int i = 0; i < 40; i++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        doReq(lfsr[31], {14'h0, lfsr[10:8]}, lfsr[27:12], (lfsr[31] ? lfsr[5:4] : 2'b11));
        if (lfsr[6]) repeat (int'(lfsr[3:2])) @(negedge clk);
      end
    end
    repeat (RC + 4) @(negedge clk);
    finishRun();
  end

endmodule